// File: doc/BRIEF.md
# Indirect Memory Window with Auto-Increment

This block gives a host on a narrow byte-wide I/O bus a way into a 32-bit wide internal memory. It is reached through eight byte registers at consecutive offsets. Two of them are general-purpose mailbox bytes, two hold a byte address and an access mode, and four are data ports. The four data ports are the byte lanes of the memory word that the address currently selects.

A host first programs the address and the mode. It then reads or writes the data ports. In the incrementing 32-bit mode, any access to the highest data port moves the address on to the next word. A stream of bytes can therefore be moved by cycling through the four data ports with no further address writes. The stream may begin at any lane, because each data port maps to a fixed lane.

The address is 15 bits wide and counts bytes. The two lowest bits are always zero. The memory model holds `WORD_DEPTH` words and is indexed by the low bits of the word address. Higher address bits alias onto the same words.

Top module: `indirect_window`

## Requirements
- R1: After reset, both mailbox bytes read 0x00. The address readback at offsets 2 and 3 also reads 0x00, which means address 0 and mode 0.
- R2: Offsets 0 and 1 are independent byte latches. A read returns the last byte written to the same offset.
- R3: A write to offset 2 loads byte-address bits [7:2] from data bits [7:2] and the access mode from data bits [1:0]. Here 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is 32-bit with auto-increment. A read of offset 2 returns {address[7:2], mode}.
- R4: A write to offset 3 loads address bits [14:8] from data bits [6:0], and data bit 7 is dropped. A read returns {0, address[14:8]}.
- R5: A write to offset 4+k (k = 0..3) changes only byte lane k, which is bits [8k+7:8k] of the addressed memory word. The other three lanes are left as they were.
- R6: A read of offset 4+k returns lane k of the addressed word in the same cycle.
- R7: In mode 3, a read or a write of offset 7 advances the address by 4 after that access. Accesses to offsets 4 to 6 leave the address unchanged.
- R8: In modes 0, 1 and 2, accesses to offsets 4 to 7 never change the address.
- R9: The advance wraps modulo 2^15, so address 0x7FFC is followed by 0x0000.
- R10: The memory word index is the low log2(WORD_DEPTH) bits of address[14:2]. Addresses that differ only above those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Write strobe for one cycle |
| hostRd | input | 1 | Read strobe for one cycle |
| hostOff | input | 3 | Register offset within the window |
| hostWdata | input | 8 | Write data byte |
| hostRdata | output | 8 | Read data byte, combinational from hostOff |

## Verification
Read data is combinational. It is due in the same cycle as the read strobe, so the bench drives each access at a falling edge and samples one time unit later, before the rising edge. Every register update is due at the rising edge that ends the access: mailbox loads, address and mode loads, lane writes and the auto-increment. The bench therefore lets that edge pass before it starts the next access. The bench's own model of the address and memory is updated at the same point. Each later read then compares against state that includes every earlier access.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

  // Byte address width fixed by the two address registers (6 + 7 bits of word address)
  localparam int WIN_ADDR_W  = 15;
  localparam int WIN_WORD_AW = WIN_ADDR_W - 2;

  typedef enum logic [1:0] {
    MODE_BYTE     = 2'd0,
    MODE_HALF     = 2'd1,
    MODE_WORD     = 2'd2,
    MODE_WORD_INC = 2'd3
  } accMode_t;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic       mboxALd;
    logic       mboxBLd;
    logic       addrLoLd;
    logic       addrHiLd;
    logic       laneWr;
    logic [1:0] lane;
    logic       advance;
  } winStrobes_t;

endpackage

// File: rtl/iwin_ctrl.sv
module iwin_ctrl
  import iwin_pkg::*;
(
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [2:0]  hostOff,
  input  accMode_t    curMode,
  output winStrobes_t strobes
);

  logic anyAccess;

  always_comb begin
    anyAccess = hostWr | hostRd;
    strobes   = '0;
    case (hostOff)
      3'd0: strobes.mboxALd  = hostWr;
      3'd1: strobes.mboxBLd  = hostWr;
      3'd2: strobes.addrLoLd = hostWr;
      3'd3: strobes.addrHiLd = hostWr;
      default: begin
        // offsets 4..7 are data lanes 0..3
        strobes.laneWr  = hostWr;
        strobes.lane    = hostOff[1:0];
        strobes.advance = anyAccess && (hostOff[1:0] == 2'd3) &&
                          (curMode == MODE_WORD_INC);
      end
    endcase
  end

endmodule

// File: rtl/iwin_ram.sv
module iwin_ram #(
  parameter int WORD_DEPTH = 256,
  localparam int IDX_W     = $clog2(WORD_DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [1:0]       wrLane,
  input  logic [7:0]       wrByte,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      rdWord
);

  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] laneMem [WORD_DEPTH];

    always_ff @(posedge clk) begin
      if (wrEn && (wrLane == 2'(ln)))
        laneMem[idx] <= wrByte;
    end

    assign rdWord[8*ln +: 8] = laneMem[idx];
  end

endmodule

// File: rtl/iwin_dp.sv
module iwin_dp
  import iwin_pkg::*;
#(
  parameter int WORD_DEPTH = 256,
  localparam int IDX_W     = $clog2(WORD_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  winStrobes_t           strobes,
  input  logic [2:0]            hostOff,
  input  logic [7:0]            hostWdata,
  output logic [7:0]            hostRdata,
  output logic [WIN_ADDR_W-1:0] curAddr,
  output accMode_t              curMode
);

  logic [7:0]             mboxAQ, mboxBQ;
  logic [WIN_WORD_AW-1:0] wordAddrQ;
  accMode_t               modeQ;
  logic [31:0]            rdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mboxAQ    <= '0;
      mboxBQ    <= '0;
      wordAddrQ <= '0;
      modeQ     <= MODE_BYTE;
    end else begin
      if (strobes.mboxALd) mboxAQ <= hostWdata;
      if (strobes.mboxBLd) mboxBQ <= hostWdata;
      if (strobes.addrLoLd) begin
        wordAddrQ[5:0] <= hostWdata[7:2];
        modeQ          <= accMode_t'(hostWdata[1:0]);
      end
      if (strobes.addrHiLd)
        wordAddrQ[WIN_WORD_AW-1:6] <= hostWdata[WIN_WORD_AW-7:0];
      if (strobes.advance)
        wordAddrQ <= wordAddrQ + WIN_WORD_AW'(1);
    end
  end

  iwin_ram #(.WORD_DEPTH(WORD_DEPTH)) u_ram (
    .clk    (clk),
    .wrEn   (strobes.laneWr),
    .wrLane (strobes.lane),
    .wrByte (hostWdata),
    .idx    (wordAddrQ[IDX_W-1:0]),
    .rdWord (rdWord)
  );

  always_comb begin
    case (hostOff)
      3'd0:    hostRdata = mboxAQ;
      3'd1:    hostRdata = mboxBQ;
      3'd2:    hostRdata = {wordAddrQ[5:0], modeQ};
      3'd3:    hostRdata = {1'b0, wordAddrQ[WIN_WORD_AW-1:6]};
      default: hostRdata = rdWord[8*hostOff[1:0] +: 8];
    endcase
  end

  assign curAddr = {wordAddrQ, 2'b00};
  assign curMode = modeQ;

endmodule

// File: rtl/indirect_window.sv
module indirect_window
  import iwin_pkg::*;
#(
  parameter int WORD_DEPTH = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [2:0] hostOff,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata
);

  winStrobes_t           strobes;
  logic [WIN_ADDR_W-1:0] curAddr;
  accMode_t              curMode;

  iwin_ctrl u_ctrl (
    .hostWr  (hostWr),
    .hostRd  (hostRd),
    .hostOff (hostOff),
    .curMode (curMode),
    .strobes (strobes)
  );

  iwin_dp #(.WORD_DEPTH(WORD_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostOff   (hostOff),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .curAddr   (curAddr),
    .curMode   (curMode)
  );

endmodule

// File: rtl/iwin_checker.sv
module iwin_checker (
  input logic        clk,
  input logic        rstN,
  input logic        hostWr,
  input logic        hostRd,
  input logic [2:0]  hostOff,
  input logic [7:0]  hostWdata,
  input logic [7:0]  hostRdata,
  input logic [14:0] curAddr,
  input logic [1:0]  curMode
);

  // R7 / R9: an access of offset 7 in mode 3 moves the address on by one word, wrapping
  p_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((hostWr || hostRd) && hostOff == 3'd7 && curMode == 2'd3)
      |=> (curAddr == $past(curAddr) + 15'd4));

  // R8: data accesses outside mode 3 keep the address
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((hostWr || hostRd) && hostOff[2] && curMode != 2'd3) |=> $stable(curAddr));

  // R7: data lanes 0..2 never advance
  p_no_adv_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((hostWr || hostRd) && hostOff[2] && hostOff[1:0] != 2'd3) |=> $stable(curAddr));

  // R4: the top bit of the upper address byte reads as zero
  p_hi_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostOff == 3'd3) |-> (hostRdata[7] == 1'b0));

  // R2: a mailbox byte written is read back on the next cycle
  p_mbox_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostOff == 3'd0) ##1 (hostOff == 3'd0) |-> (hostRdata == $past(hostWdata)));

  // R1: address readback is zero straight after reset
  p_reset_r1: assert property (@(posedge clk)
    (!$past(rstN) && rstN) |-> (curAddr == 15'd0 && curMode == 2'd0));

endmodule

bind indirect_window iwin_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWr    (hostWr),
  .hostRd    (hostRd),
  .hostOff   (hostOff),
  .hostWdata (hostWdata),
  .hostRdata (hostRdata),
  .curAddr   (curAddr),
  .curMode   (curMode)
);

// File: tb/indirect_window_tb.sv
module indirect_window_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hostWr, hostRd;
  logic [2:0] hostOff;
  logic [7:0] hostWdata;
  logic [7:0] hostRdata;

  int vectors = 0;
  int errs    = 0;

  logic [31:0] model [256];
  logic [14:0] mAddr;
  logic [1:0]  mMode;
  logic [7:0]  mbA, mbB;

  always #4 clk = ~clk;

  indirect_window #(.WORD_DEPTH(256)) u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostOff(hostOff), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  // One bus access; reads are compared against the bench model
  task automatic touch(input bit isWr, input logic [2:0] off, input logic [7:0] d,
                       input string tag);
    logic [7:0] expv;
    logic [7:0] idx;
    @(negedge clk);
    hostWr = isWr; hostRd = !isWr; hostOff = off; hostWdata = d;
    idx = mAddr[9:2];
    case (off)
      3'd0:    expv = mbA;
      3'd1:    expv = mbB;
      3'd2:    expv = {mAddr[7:2], mMode};
      3'd3:    expv = {1'b0, mAddr[14:8]};
      default: expv = model[idx][8*off[1:0] +: 8];
    endcase
    #1;
    if (!isWr) begin
      vectors++;
      if (hostRdata !== expv) begin
        errs++;
        $display("FAIL %s off=%0d addr=%04h got %02h exp %02h", tag, off, mAddr, hostRdata, expv);
      end
    end
    @(posedge clk);
    #1 hostWr = 1'b0; hostRd = 1'b0;
    if (isWr) begin
      case (off)
        3'd0: mbA = d;
        3'd1: mbB = d;
        3'd2: begin mAddr[7:0] = {d[7:2], 2'b00}; mMode = d[1:0]; end
        3'd3: mAddr[14:8] = d[6:0];
        default: model[idx][8*off[1:0] +: 8] = d;
      endcase
    end
    if (off == 3'd7 && mMode == 2'd3) mAddr = mAddr + 15'd4;
  endtask

  task automatic setAddr(input logic [14:0] a, input logic [1:0] m);
    touch(1'b1, 3'd2, {a[7:2], m}, "R3");
    touch(1'b1, 3'd3, {1'b0, a[14:8]}, "R4");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog (R1) got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    rstN = 1'b0; hostWr = 1'b0; hostRd = 1'b0; hostOff = '0; hostWdata = '0;
    mAddr = '0; mMode = '0; mbA = '0; mbB = '0;
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset values
    for (int o = 0; o < 4; o++) touch(1'b0, 3'(o), 8'h00, "R1");

    // R2: mailbox latches
    for (int v = 0; v < 256; v += 15) begin
      touch(1'b1, 3'd0, 8'(v), "R2");
      touch(1'b1, 3'd1, ~8'(v), "R2");
      touch(1'b0, 3'd0, 8'h00, "R2");
      touch(1'b0, 3'd1, 8'h00, "R2");
    end

    // R5/R7: fill every word through the auto-incrementing stream
    setAddr(15'h0000, 2'd3);
    for (int i = 0; i < 1024; i++) touch(1'b1, 3'(4 + i % 4), 8'(i * 37 + 5), "R5");
    touch(1'b0, 3'd2, 8'h00, "R3");
    touch(1'b0, 3'd3, 8'h00, "R3");
    // R10: address 0x400 aliases onto word 0
    touch(1'b0, 3'd4, 8'h00, "R10");

    // R6/R7: stream everything back
    setAddr(15'h0000, 2'd3);
    for (int i = 0; i < 1024; i++) touch(1'b0, 3'(4 + i % 4), 8'h00, "R6");

    // R7: start mid-word, lane 2 -> lane 3 -> next word lane 0
    setAddr(15'h0010, 2'd3);
    touch(1'b1, 3'd6, 8'hC6, "R7");
    touch(1'b1, 3'd7, 8'hC7, "R7");
    touch(1'b1, 3'd4, 8'hC4, "R7");
    touch(1'b0, 3'd2, 8'h00, "R7");
    setAddr(15'h0010, 2'd2);
    for (int o = 4; o < 8; o++) touch(1'b0, 3'(o), 8'h00, "R7");
    setAddr(15'h0014, 2'd2);
    for (int o = 4; o < 8; o++) touch(1'b0, 3'(o), 8'h00, "R7");

    // R7: lanes 0..2 do not advance in mode 3
    setAddr(15'h0030, 2'd3);
    for (int o = 4; o < 7; o++) begin
      touch(1'b0, 3'(o), 8'h00, "R7");
      touch(1'b1, 3'(o), 8'(o * 3), "R7");
    end
    touch(1'b0, 3'd2, 8'h00, "R7");

    // R8/R5: modes 0..2 hold the address; single-lane writes
    for (int m = 0; m < 3; m++) begin
      setAddr(15'h0020 + 15'(m * 4), 2'(m));
      for (int k = 0; k < 5; k++) touch(1'b0, 3'd7, 8'h00, "R8");
      touch(1'b1, 3'd7, 8'h70 + 8'(m), "R8");
      touch(1'b0, 3'd2, 8'h00, "R8");
      touch(1'b0, 3'd3, 8'h00, "R8");
      touch(1'b1, 3'(5 + m), 8'h5A + 8'(m), "R5");
      for (int o = 4; o < 8; o++) touch(1'b0, 3'(o), 8'h00, "R5");
    end

    // R4: bit 7 of the upper byte is dropped
    touch(1'b1, 3'd3, 8'hFF, "R4");
    touch(1'b0, 3'd3, 8'h00, "R4");
    // R9/R10: top of space, alias to word 255, then wrap
    touch(1'b1, 3'd2, 8'hFF, "R3");
    touch(1'b0, 3'd2, 8'h00, "R3");
    touch(1'b0, 3'd4, 8'h00, "R10");
    touch(1'b0, 3'd7, 8'h00, "R9");
    touch(1'b0, 3'd2, 8'h00, "R9");
    touch(1'b0, 3'd3, 8'h00, "R9");
    touch(1'b0, 3'd4, 8'h00, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule